// File: doc/BRIEF.md
# Programmable Interval Timer with Single-Shot Mode

This block counts pulses from one of four slow tick sources and signals an event when the count reaches a programmed interval. Software writes a configuration word through a one-cycle write strobe. The word holds a run bit, a single-shot bit, a 2-bit source select and an 8-bit interval. The tick sources arrive as single-cycle enables on an input vector. Generating those ticks from a crystal is outside this block.

Run, source select and interval are first held as requests. They become active only on a 128 Hz reference tick, which models the hand-off into the slow time domain. Software can watch the hand-off through the run and select readbacks, because these show the active values. The single-shot bit acts at once.

In repeat mode the counter restarts after every event. In single-shot mode it parks at zero after the first event and stays there until it is released. A sticky event flag records events until software clears it.

Top module: `itv_timer`

## Requirements
- R1: After synchronous reset, count, evt, flag, run_rb and sel_rb are all zero.
- R2: A written run value becomes active, and is visible on run_rb, only at a clock edge with ref_tick high that comes after the write edge. A write in the same cycle as ref_tick waits for the next ref_tick. Clearing run therefore leaves run_rb at 1 until that tick.
- R3: A written source select becomes active, and is visible on sel_rb, only at the next ref_tick after the write. Until then, ticks are taken from the previously active source.
- R4: A written interval becomes the compare value only at the next ref_tick after the write. Until then, events use the old interval.
- R5: While running, the count advances by one on each edge where tick_src[s] is high, with s the active select (select value k picks bit k). Pulses on other source bits leave the count unchanged.
- R6: When a selected tick arrives while count equals the active interval, evt is high for that one cycle and count returns to 0. The period is therefore interval+1 ticks. An interval of 0 fires on every selected tick.
- R7: With the single-shot bit clear (repeat mode), counting resumes from 0 after an event, and further events follow.
- R8: With the single-shot bit set, count stays at 0 after an event and selected ticks produce no further events. The hold is released one cycle after a write that clears the single-shot bit, or by the active run going to 0 and back to 1.
- R9: flag goes to 1 with every evt and stays at 1 until flag_clr is high. If an event and flag_clr fall in the same cycle, flag ends at 1.
- R10: While the active run is 0, the count is 0 one cycle later and selected ticks do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | 128 Hz reference tick, one cycle wide |
| tick_src | input | 4 | Four timebase tick enables, one cycle wide each |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Requested run bit |
| cfg_oneshot | input | 1 | Single-shot mode bit, active at once |
| cfg_sel | input | 2 | Requested timebase select |
| cfg_interval | input | 8 | Requested interval |
| flag_clr | input | 1 | Software clear of the event flag |
| run_rb | output | 1 | Active run bit |
| sel_rb | output | 2 | Active timebase select |
| count | output | 8 | Current count |
| evt | output | 1 | One-cycle event pulse |
| flag | output | 1 | Sticky event flag |

## Verification
Two collisions are provoked on purpose. The first is an event and a software flag clear in the same cycle. The bench sets the interval to 0, so the next selected tick is certain to fire, and pulses that tick together with flag_clr. The flag must read 1 afterwards, and a lone clear one cycle later must take it to 0.

The second is a configuration write in the same cycle as a reference tick. The bench clears run together with ref_tick and expects run_rb to stay at 1. It expects the change to appear only after a later reference tick, with the count reaching 0 one cycle after that.

// File: rtl/itv_pkg.sv
package itv_pkg;

    localparam int ITV_CNT_W_DEF = 8;
    localparam int ITV_NSRC_DEF  = 4;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_COUNT = 2'd1,
        PH_HOLD  = 2'd2
    } itv_phase_e;

    function automatic logic itv_hit(input logic [31:0] cnt, input logic [31:0] lim);
        return cnt == lim;
    endfunction

endpackage

// File: rtl/itv_cfg_sync.sv
module itv_cfg_sync #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic             cfg_oneshot,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CNT_W-1:0] cfg_interval,
    output logic             act_run,
    output logic [SEL_W-1:0] act_sel,
    output logic [CNT_W-1:0] act_intv,
    output logic             oneshot
);
    logic             req_run;
    logic [SEL_W-1:0] req_sel;
    logic [CNT_W-1:0] req_intv;

    // Request side: captured on every write.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_run  <= 1'b0;
            req_sel  <= '0;
            req_intv <= '0;
            oneshot  <= 1'b0;
        end else if (cfg_we) begin
            req_run  <= cfg_run;
            req_sel  <= cfg_sel;
            req_intv <= cfg_interval;
            oneshot  <= cfg_oneshot;
        end
    end

    // Active side: takes the held request at a reference tick only.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_run  <= 1'b0;
            act_sel  <= '0;
            act_intv <= '0;
        end else if (ref_tick) begin
            act_run  <= req_run;
            act_sel  <= req_sel;
            act_intv <= req_intv;
        end
    end
endmodule

// File: rtl/itv_count.sv
module itv_count
    import itv_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_run,
    input  logic [SEL_W-1:0] act_sel,
    input  logic [CNT_W-1:0] act_intv,
    input  logic             oneshot,
    input  logic [N_SRC-1:0] tick_src,
    output logic [CNT_W-1:0] count,
    output logic             evt
);
    itv_phase_e       ph, ph_n;
    logic [CNT_W-1:0] cnt_n;
    logic             fire;
    logic             tick;

    assign tick = tick_src[act_sel];

    always_comb begin
        ph_n  = ph;
        cnt_n = count;
        fire  = 1'b0;
        if (!act_run) begin
            ph_n  = PH_OFF;
            cnt_n = '0;
        end else if (ph == PH_HOLD) begin
            cnt_n = '0;
            if (!oneshot) ph_n = PH_COUNT;
        end else begin
            ph_n = PH_COUNT;
            if (tick) begin
                if (itv_hit(32'(count), 32'(act_intv))) begin
                    fire  = 1'b1;
                    cnt_n = '0;
                    if (oneshot) ph_n = PH_HOLD;
                end else begin
                    cnt_n = count + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_OFF;
            count <= '0;
            evt   <= 1'b0;
        end else begin
            ph    <= ph_n;
            count <= cnt_n;
            evt   <= fire;
        end
    end
endmodule

// File: rtl/itv_flag.sv
module itv_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end
endmodule

// File: rtl/itv_timer.sv
module itv_timer
    import itv_pkg::*;
#(
    parameter int CNT_W = ITV_CNT_W_DEF,
    parameter int N_SRC = ITV_NSRC_DEF,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [N_SRC-1:0] tick_src,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic             cfg_oneshot,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             flag_clr,
    output logic             run_rb,
    output logic [SEL_W-1:0] sel_rb,
    output logic [CNT_W-1:0] count,
    output logic             evt,
    output logic             flag
);
    logic             act_run;
    logic [SEL_W-1:0] act_sel;
    logic [CNT_W-1:0] act_intv;
    logic             oneshot;
    logic             evt_q;

    itv_cfg_sync #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .ref_tick     (ref_tick),
        .cfg_we       (cfg_we),
        .cfg_run      (cfg_run),
        .cfg_oneshot  (cfg_oneshot),
        .cfg_sel      (cfg_sel),
        .cfg_interval (cfg_interval),
        .act_run      (act_run),
        .act_sel      (act_sel),
        .act_intv     (act_intv),
        .oneshot      (oneshot)
    );

    itv_count #(.CNT_W(CNT_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .act_run  (act_run),
        .act_sel  (act_sel),
        .act_intv (act_intv),
        .oneshot  (oneshot),
        .tick_src (tick_src),
        .count    (count),
        .evt      (evt_q)
    );

    // The flag is set from the same edge decision as the pulse: both rise together.
    itv_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (u_cnt.fire),
        .clr_i (flag_clr),
        .flag  (flag)
    );

    assign run_rb = act_run;
    assign sel_rb = act_sel;
    assign evt    = evt_q;
endmodule

module itv_timer_chk #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_tick,
    input logic             flag_clr,
    input logic             run_rb,
    input logic [SEL_W-1:0] sel_rb,
    input logic [CNT_W-1:0] count,
    input logic             evt,
    input logic             flag
);
    AST_RUN_ONLY_AT_REF: assert property (@(posedge clk) disable iff (rst) !ref_tick |=> $stable(run_rb)); // R2
    AST_SEL_ONLY_AT_REF: assert property (@(posedge clk) disable iff (rst) !ref_tick |=> $stable(sel_rb)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || count == '0)); // R5
    AST_EVT_ZEROES: assert property (@(posedge clk) disable iff (rst) evt |-> count == '0); // R6
    AST_EVT_FLAG: assert property (@(posedge clk) disable iff (rst) evt |-> flag); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (flag && !flag_clr) |=> flag); // R9
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst) !run_rb |=> count == '0); // R10
endmodule

bind itv_timer itv_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .flag_clr (flag_clr),
    .run_rb   (run_rb),
    .sel_rb   (sel_rb),
    .count    (count),
    .evt      (evt),
    .flag     (flag)
);

// File: tb/itv_timer_tb.sv
`timescale 1ns/1ps
module itv_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic [3:0] tick_src = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_run = 1'b0;
    logic       cfg_oneshot = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_interval = '0;
    logic       flag_clr = 1'b0;
    logic       run_rb;
    logic [1:0] sel_rb;
    logic [7:0] count;
    logic       evt;
    logic       flag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    itv_timer u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .tick_src(tick_src),
        .cfg_we(cfg_we), .cfg_run(cfg_run), .cfg_oneshot(cfg_oneshot),
        .cfg_sel(cfg_sel), .cfg_interval(cfg_interval), .flag_clr(flag_clr),
        .run_rb(run_rb), .sel_rb(sel_rb), .count(count), .evt(evt), .flag(flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic run, input logic os, input logic [1:0] sel, input logic [7:0] iv);
        cfg_we = 1'b1; cfg_run = run; cfg_oneshot = os; cfg_sel = sel; cfg_interval = iv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ref1();
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic tk(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            tick_src = m;
            @(negedge clk);
            tick_src = '0;
        end
    endtask

    task automatic clr1();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 evt", evt, 0);
        chk("R1 flag", flag, 0);
        chk("R1 run_rb", run_rb, 0);
        chk("R1 sel_rb", sel_rb, 0);
    endtask

    task automatic t_sync();
        wr(1'b1, 1'b0, 2'd2, 8'd3);
        chk("R2 run before ref", run_rb, 0);
        chk("R3 sel before ref", sel_rb, 0);
        ref1();
        chk("R2 run after ref", run_rb, 1);
        chk("R3 sel after ref", sel_rb, 2);
        tk(4'b0001, 1);
        chk("R5 other source ignored", count, 0);
        tk(4'b0100, 2);
        chk("R5 selected source counts", count, 2);
        wr(1'b1, 1'b0, 2'd3, 8'd3);
        tk(4'b0100, 1);
        chk("R3 old source still used", count, 3);
        tk(4'b1000, 1);
        chk("R3 new source not yet used", count, 3);
        ref1();
        chk("R3 sel switched", sel_rb, 3);
        tk(4'b1000, 1);
        chk("R6 event pulse", evt, 1);
        chk("R6 count wraps", count, 0);
        chk("R9 flag set", flag, 1);
        // write in the same cycle as a reference tick
        cfg_we = 1'b1; cfg_run = 1'b0; ref_tick = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; ref_tick = 1'b0;
        chk("R2 same-cycle write deferred", run_rb, 1);
        tk(4'b1000, 1);
        chk("R2 still counting", count, 1);
        ref1();
        chk("R2 run cleared at ref", run_rb, 0);
        idle(1);
        chk("R10 count zero when off", count, 0);
        tk(4'b1000, 2);
        chk("R10 ticks ignored when off", count, 0);
        clr1();
        chk("R9 flag cleared", flag, 0);
    endtask

    task automatic t_repeat();
        wr(1'b1, 1'b0, 2'd1, 8'd2);
        ref1();
        tk(4'b0010, 2);
        chk("R6 no early event", evt, 0);
        chk("R5 count two", count, 2);
        tk(4'b0010, 1);
        chk("R6 event at interval", evt, 1);
        chk("R9 flag on event", flag, 1);
        idle(1);
        chk("R6 pulse one cycle", evt, 0);
        tk(4'b0010, 2);
        chk("R7 count resumes", count, 2);
        tk(4'b0010, 1);
        chk("R7 second event", evt, 1);
        wr(1'b1, 1'b0, 2'd1, 8'd5);
        tk(4'b0010, 3);
        chk("R4 old interval kept", evt, 1);
        ref1();
        tk(4'b0010, 5);
        chk("R4 new interval no event", evt, 0);
        chk("R4 count five", count, 5);
        tk(4'b0010, 1);
        chk("R4 new interval event", evt, 1);
        wr(1'b1, 1'b0, 2'd1, 8'd0);
        ref1();
        tk(4'b0010, 1);
        chk("R6 zero interval fires", evt, 1);
        tk(4'b0010, 1);
        chk("R6 zero interval again", evt, 1);
        clr1();
        chk("R9 cleared", flag, 0);
        tick_src = 4'b0010; flag_clr = 1'b1;
        @(negedge clk);
        tick_src = '0; flag_clr = 1'b0;
        chk("R9 set wins over clear", flag, 1);
        clr1();
        chk("R9 lone clear", flag, 0);
    endtask

    task automatic t_oneshot();
        wr(1'b1, 1'b1, 2'd1, 8'd1);
        ref1();
        tk(4'b0010, 1);
        chk("R8 count one", count, 1);
        tk(4'b0010, 1);
        chk("R8 first event", evt, 1);
        clr1();
        tk(4'b0010, 3);
        chk("R8 held count", count, 0);
        chk("R8 no further event", flag, 0);
        wr(1'b1, 1'b0, 2'd1, 8'd1);
        idle(1);
        tk(4'b0010, 1);
        chk("R8 released by mode clear", count, 1);
        tk(4'b0010, 1);
        chk("R8 event after release", evt, 1);
        wr(1'b1, 1'b1, 2'd1, 8'd1);
        tk(4'b0010, 2);
        chk("R8 second single event", evt, 1);
        tk(4'b0010, 1);
        chk("R8 held again", count, 0);
        wr(1'b0, 1'b1, 2'd1, 8'd1);
        ref1();
        idle(1);
        wr(1'b1, 1'b1, 2'd1, 8'd1);
        ref1();
        tk(4'b0010, 1);
        chk("R8 released by run toggle", count, 1);
        tk(4'b0010, 1);
        chk("R8 event after run toggle", evt, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_sync();
        t_repeat();
        t_oneshot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule